// File: doc/BRIEF.md
# Rounding Multiplier-Accumulator with Sectioned Preload

This block multiplies two 16-bit operands and folds the 32-bit product into a 35-bit accumulator. Operand A and operand B are captured on their own clocks. The mode controls are captured on the rising edge of the OR of those two clocks. The controls are rounding, signed/unsigned selection and the accumulate mode. A separate result clock updates the accumulator. Each update loads the product, adds the product to the accumulator, or forms the product minus the accumulator. Products are sign-extended in signed mode and zero-extended in unsigned mode. All accumulator arithmetic wraps modulo 2^35.

The accumulator is presented as three sections: a 3-bit extension, a 16-bit high word and a 16-bit low word. Each section has its own driver-disable input. While the preload control is high, every section whose drivers are disabled loads the value on its own pin bus at the result clock edge. The low-word pins also carry operand B. Pads are modelled as separate input, output and output-enable signals. The encoding acc=0, sub=1 is reserved and holds the accumulator, and its value is not part of the contract.

Top module: `mac16_preload`

## Requirements
- R1: Operand A is taken from `a_in` only on a rising edge of `clk_a`, and operand B from `l_pin_in` only on a rising edge of `clk_b`. Input changes between those edges do not affect later results.
- R2: `rnd`, `tc`, `acc` and `sub` are taken on every rising edge of `clk_a | clk_b`, so a pulse on `clk_a` alone also updates the controls.
- R3: With `tc`=1 both operands are two's complement; with `tc`=0 both are unsigned.
- R4: With `rnd`=1, 2^15 is added to the 32-bit product before it is used.
- R5: The product is widened to 35 bits, by sign extension of bit 31 when `tc`=1 and by zero extension when `tc`=0.
- R6: With `prel`=0, `acc`=0 and `sub`=0, the accumulator loads the widened product on a rising edge of `clk_r`.
- R7: With `prel`=0, `acc`=1 and `sub`=0, the accumulator takes product plus accumulator, modulo 2^35.
- R8: With `prel`=0, `acc`=1 and `sub`=1, the accumulator takes product minus accumulator, modulo 2^35.
- R9: `x_out` shows accumulator bits 34..32, `m_out` shows bits 31..16 and `l_out` shows bits 15..0. Each section's enable output is the inverse of its `*_hiz` input.
- R10: With `prel`=1, every section whose `*_hiz` is 1 loads its own pin input on a rising edge of `clk_r`.
- R11: With `prel`=1, no arithmetic update happens, and sections whose `*_hiz` is 0 keep their contents.
- R12: While `rst_n` is low, the operand registers, the control register and the accumulator are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Operand A capture clock |
| clk_b | input | 1 | Operand B capture clock |
| clk_r | input | 1 | Accumulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 16 | Operand A |
| rnd | input | 1 | Add 2^15 to the product |
| tc | input | 1 | 1: signed operands, 0: unsigned |
| acc | input | 1 | Accumulate mode bit |
| sub | input | 1 | Subtract mode bit |
| prel | input | 1 | Preload select |
| x_hiz | input | 1 | Extension section drivers off |
| m_hiz | input | 1 | High word drivers off |
| l_hiz | input | 1 | Low word drivers off |
| x_pin_in | input | 3 | Extension pin input |
| m_pin_in | input | 16 | High word pin input |
| l_pin_in | input | 16 | Low word pin input, also operand B |
| x_out | output | 3 | Extension section value |
| x_oe | output | 1 | Extension driver enable |
| m_out | output | 16 | High word value |
| m_oe | output | 1 | High word driver enable |
| l_out | output | 16 | Low word value |
| l_oe | output | 1 | Low word driver enable |

## Verification
The bench targets these corner cases:
- Signed operands of -32768 times -32768 with rounding. A design that dropped the extra width or rounded at the wrong bit returns a wrong high word.
- A negative product, whose extension bits must read 7. Zero extension there would read 0.
- A preload of all ones followed by an add of 1. This checks the wrap to zero at 35 bits.
- Partial preloads, where untouched sections must keep their contents.
- A pulse on `clk_a` alone. It must update the controls but leave operand B unchanged, even though the shared low-word pins are changing at the same time.

// File: rtl/mac16_pkg.sv
package mac16_pkg;
    typedef struct packed {
        logic rnd;
        logic tc;
        logic acc;
        logic sub;
    } mac_ctl_t;
endpackage

// File: rtl/mac16_capreg.sv
module mac16_capreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] qout
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign qout = val_q;
endmodule

// File: rtl/mac16_mult.sv
module mac16_mult #(
    parameter int OPW = 16,
    parameter int XW  = 3
) (
    input  logic [OPW-1:0]        op_a,
    input  logic [OPW-1:0]        op_b,
    input  logic                  tc,
    input  logic                  rnd,
    output logic [2*OPW+XW-1:0]   prod_ext
);
    localparam int PW = 2 * OPW;
    localparam int AW = PW + XW;
    localparam logic [PW-1:0] HALF_LSB = PW'(1) << (OPW - 1);

    logic [PW-1:0] wa, wb, full, rounded;

    always_comb begin
        // Widen each operand to the product width; signed mode replicates the sign bit
        wa = tc ? {{OPW{op_a[OPW-1]}}, op_a} : {{OPW{1'b0}}, op_a};
        wb = tc ? {{OPW{op_b[OPW-1]}}, op_b} : {{OPW{1'b0}}, op_b};
        full = wa * wb;
        rounded = full + (rnd ? HALF_LSB : '0);
        if (tc) prod_ext = {{XW{rounded[PW-1]}}, rounded};
        else    prod_ext = {{XW{1'b0}}, rounded};
    end

    logic unused_width;
    assign unused_width = (AW > 0) ? 1'b0 : 1'b1;
endmodule

// File: rtl/mac16_accum.sv
module mac16_accum #(
    parameter int OPW = 16,
    parameter int XW  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*OPW+XW-1:0] prod_ext,
    input  logic                acc,
    input  logic                sub,
    input  logic                prel,
    input  logic                x_hiz,
    input  logic                m_hiz,
    input  logic                l_hiz,
    input  logic [XW-1:0]       x_pin,
    input  logic [OPW-1:0]      m_pin,
    input  logic [OPW-1:0]      l_pin,
    output logic [2*OPW+XW-1:0] acc_val
);
    localparam int AW = 2 * OPW + XW;

    typedef struct packed {
        logic [XW-1:0]  x;
        logic [OPW-1:0] m;
        logic [OPW-1:0] l;
    } sect_t;

    sect_t st_d, st_q;
    logic [AW-1:0] cur, sum, dif;

    always_comb begin
        cur  = st_q;
        sum  = prod_ext + cur;
        dif  = prod_ext - cur;
        st_d = st_q;
        if (prel) begin
            if (x_hiz) st_d.x = x_pin;
            if (m_hiz) st_d.m = m_pin;
            if (l_hiz) st_d.l = l_pin;
        end else begin
            unique case ({acc, sub})
                2'b00:   st_d = prod_ext;
                2'b10:   st_d = sum;
                2'b11:   st_d = dif;
                default: st_d = st_q;   // reserved code: hold
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_val = st_q;
endmodule

// File: rtl/mac16_preload.sv
module mac16_preload
    import mac16_pkg::*;
#(
    parameter int OPW = 16,
    parameter int XW  = 3
) (
    input  logic           clk_a,
    input  logic           clk_b,
    input  logic           clk_r,
    input  logic           rst_n,
    input  logic [OPW-1:0] a_in,
    input  logic           rnd,
    input  logic           tc,
    input  logic           acc,
    input  logic           sub,
    input  logic           prel,
    input  logic           x_hiz,
    input  logic           m_hiz,
    input  logic           l_hiz,
    input  logic [XW-1:0]  x_pin_in,
    input  logic [OPW-1:0] m_pin_in,
    input  logic [OPW-1:0] l_pin_in,
    output logic [XW-1:0]  x_out,
    output logic           x_oe,
    output logic [OPW-1:0] m_out,
    output logic           m_oe,
    output logic [OPW-1:0] l_out,
    output logic           l_oe
);
    localparam int PW = 2 * OPW;
    localparam int AW = PW + XW;
    localparam int CW = $bits(mac_ctl_t);

    logic           ctl_clk;
    logic [OPW-1:0] a_q, b_q;
    logic [CW-1:0]  ctl_raw;
    mac_ctl_t       ctl_q;
    logic [AW-1:0]  prod_ext;
    logic [AW-1:0]  acc_val;

    assign ctl_clk = clk_a | clk_b;

    mac16_capreg #(.W(OPW)) u_areg (
        .clk(clk_a), .rst_n(rst_n), .din(a_in), .qout(a_q)
    );
    mac16_capreg #(.W(OPW)) u_breg (
        .clk(clk_b), .rst_n(rst_n), .din(l_pin_in), .qout(b_q)
    );
    mac16_capreg #(.W(CW)) u_creg (
        .clk(ctl_clk), .rst_n(rst_n), .din({rnd, tc, acc, sub}), .qout(ctl_raw)
    );
    assign ctl_q = mac_ctl_t'(ctl_raw);

    mac16_mult #(.OPW(OPW), .XW(XW)) u_mult (
        .op_a(a_q), .op_b(b_q), .tc(ctl_q.tc), .rnd(ctl_q.rnd), .prod_ext(prod_ext)
    );

    mac16_accum #(.OPW(OPW), .XW(XW)) u_accum (
        .clk(clk_r), .rst_n(rst_n), .prod_ext(prod_ext),
        .acc(ctl_q.acc), .sub(ctl_q.sub), .prel(prel),
        .x_hiz(x_hiz), .m_hiz(m_hiz), .l_hiz(l_hiz),
        .x_pin(x_pin_in), .m_pin(m_pin_in), .l_pin(l_pin_in),
        .acc_val(acc_val)
    );

    assign x_out = acc_val[AW-1:PW];
    assign m_out = acc_val[PW-1:OPW];
    assign l_out = acc_val[OPW-1:0];
    assign x_oe  = ~x_hiz;
    assign m_oe  = ~m_hiz;
    assign l_oe  = ~l_hiz;
endmodule

// File: rtl/mac16_preload_chk.sv
module mac16_preload_chk
    import mac16_pkg::*;
#(
    parameter int OPW = 16,
    parameter int XW  = 3
) (
    input logic                clk_r,
    input logic                rst_n,
    input logic                prel,
    input logic                x_hiz,
    input logic                m_hiz,
    input logic                l_hiz,
    input logic [XW-1:0]       x_pin_in,
    input logic [OPW-1:0]      m_pin_in,
    input logic [OPW-1:0]      l_pin_in,
    input logic [XW-1:0]       x_out,
    input logic [OPW-1:0]      m_out,
    input logic [OPW-1:0]      l_out,
    input mac_ctl_t            ctl_q,
    input logic [2*OPW+XW-1:0] prod_ext
);
    localparam int AW = 2 * OPW + XW;
    logic [AW-1:0] whole;
    assign whole = {x_out, m_out, l_out};

    assert_load_R6: assert property (@(posedge clk_r) disable iff (!rst_n)
        (!prel && !ctl_q.acc && !ctl_q.sub) |=> whole == $past(prod_ext));

    assert_add_R7: assert property (@(posedge clk_r) disable iff (!rst_n)
        (!prel && ctl_q.acc && !ctl_q.sub) |=> whole == AW'($past(prod_ext) + $past(whole)));

    assert_sub_R8: assert property (@(posedge clk_r) disable iff (!rst_n)
        (!prel && ctl_q.acc && ctl_q.sub) |=> whole == AW'($past(prod_ext) - $past(whole)));

    assert_xload_R10: assert property (@(posedge clk_r) disable iff (!rst_n)
        (prel && x_hiz) |=> x_out == $past(x_pin_in));

    assert_mload_R10: assert property (@(posedge clk_r) disable iff (!rst_n)
        (prel && m_hiz) |=> m_out == $past(m_pin_in));

    assert_lload_R10: assert property (@(posedge clk_r) disable iff (!rst_n)
        (prel && l_hiz) |=> l_out == $past(l_pin_in));

    assert_lkeep_R11: assert property (@(posedge clk_r) disable iff (!rst_n)
        (prel && !l_hiz) |=> $stable(l_out));

    assert_mkeep_R11: assert property (@(posedge clk_r) disable iff (!rst_n)
        (prel && !m_hiz) |=> $stable(m_out));
endmodule

bind mac16_preload mac16_preload_chk #(.OPW(OPW), .XW(XW)) u_chk (.*);

// File: tb/sim_mac16_preload.sv
`timescale 1ns/1ps
module sim_mac16_preload;
    localparam int AW = 35;
    localparam logic [AW-1:0] MASK = {AW{1'b1}};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic en_a = 0, en_b = 0, en_r = 0;
    logic clk_a, clk_b, clk_r;
    assign clk_a = clk & en_a;
    assign clk_b = clk & en_b;
    assign clk_r = clk & en_r;

    logic        rst_n = 0;
    logic [15:0] a_in = 0, m_pin_in = 0, l_pin_in = 0;
    logic [2:0]  x_pin_in = 0;
    logic        rnd = 0, tc = 0, acc = 0, sub = 0, prel = 0;
    logic        x_hiz = 0, m_hiz = 0, l_hiz = 0;
    logic [2:0]  x_out;
    logic [15:0] m_out, l_out;
    logic        x_oe, m_oe, l_oe;

    mac16_preload u0 (
        .clk_a(clk_a), .clk_b(clk_b), .clk_r(clk_r), .rst_n(rst_n),
        .a_in(a_in), .rnd(rnd), .tc(tc), .acc(acc), .sub(sub), .prel(prel),
        .x_hiz(x_hiz), .m_hiz(m_hiz), .l_hiz(l_hiz),
        .x_pin_in(x_pin_in), .m_pin_in(m_pin_in), .l_pin_in(l_pin_in),
        .x_out(x_out), .x_oe(x_oe), .m_out(m_out), .m_oe(m_oe),
        .l_out(l_out), .l_oe(l_oe)
    );

    int n_vec = 0, n_bad = 0;
    logic [15:0]   ma = 0, mb = 0;
    logic          mrnd = 0, mtc = 0, macc = 0, msub = 0;
    logic [AW-1:0] macc_v = 0;

    function automatic logic [AW-1:0] ref_prod(logic [15:0] a, logic [15:0] b,
                                               logic t, logic r);
        longint p;
        if (t) p = longint'($signed(a)) * longint'($signed(b));
        else   p = longint'({16'd0, a}) * longint'({16'd0, b});
        if (r) p = p + 32768;
        return p[AW-1:0];
    endfunction

    task automatic chk(string tag, logic [AW-1:0] got, logic [AW-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [AW-1:0] seen();
        return {x_out, m_out, l_out};
    endfunction

    // Capture stage: drive inputs, pulse the selected operand clocks
    task automatic capture(logic da, logic db, logic [15:0] a, logic [15:0] b,
                           logic r, logic t, logic ac, logic sb);
        @(negedge clk);
        a_in = a; l_pin_in = b; rnd = r; tc = t; acc = ac; sub = sb;
        en_a = da; en_b = db; en_r = 0;
        @(negedge clk);
        en_a = 0; en_b = 0;
        if (da) ma = a;
        if (db) mb = b;
        if (da || db) begin mrnd = r; mtc = t; macc = ac; msub = sb; end
    endtask

    // Result stage: one clk_r pulse in arithmetic mode
    task automatic update();
        logic [AW-1:0] p;
        @(negedge clk);
        prel = 0; en_r = 1;
        @(negedge clk);
        en_r = 0;
        p = ref_prod(ma, mb, mtc, mrnd);
        case ({macc, msub})
            2'b00: macc_v = p;
            2'b10: macc_v = (p + macc_v) & MASK;
            2'b11: macc_v = (p - macc_v) & MASK;
            default: ;
        endcase
    endtask

    task automatic do_op(string tag, logic [15:0] a, logic [15:0] b,
                         logic r, logic t, logic ac, logic sb);
        capture(1, 1, a, b, r, t, ac, sb);
        update();
        chk(tag, seen(), macc_v);
    endtask

    task automatic preload(logic hx, logic hm, logic hl,
                           logic [2:0] px, logic [15:0] pm, logic [15:0] pl);
        @(negedge clk);
        prel = 1; x_hiz = hx; m_hiz = hm; l_hiz = hl;
        x_pin_in = px; m_pin_in = pm; l_pin_in = pl;
        #1;
        chk("R9 oe x", {34'd0, x_oe}, {34'd0, ~hx});
        chk("R9 oe m", {34'd0, m_oe}, {34'd0, ~hm});
        chk("R9 oe l", {34'd0, l_oe}, {34'd0, ~hl});
        @(negedge clk);
        en_r = 1;
        @(negedge clk);
        en_r = 0; prel = 0; x_hiz = 0; m_hiz = 0; l_hiz = 0;
        if (hx) macc_v[34:32] = px;
        if (hm) macc_v[31:16] = pm;
        if (hl) macc_v[15:0]  = pl;
        chk("R10/R11 preload", seen(), macc_v);
    endtask

    int cycles = 0;
    bit done = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog got %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R12 reset acc", seen(), '0);
        chk("R9 reset oe", {32'd0, x_oe, m_oe, l_oe}, 35'd7);
        rst_n = 1;

        // R6/R3 unsigned load
        do_op("R6 load unsigned", 16'd5, 16'd7, 0, 0, 0, 0);
        // R1: operand inputs change with only clk_r pulsed
        @(negedge clk); a_in = 16'd1000; l_pin_in = 16'd1000;
        update();
        chk("R1 no capture without clock", seen(), 35'd35);
        // R2: clk_a only updates A and controls; B keeps 7 although pins move
        capture(1, 0, 16'd3, 16'd999, 0, 0, 1, 0);
        update();
        chk("R2 controls on clk_a alone, R1 B held", seen(), 35'd56);

        // R3/R4/R5 signed extremes
        do_op("R4 signed max rounded", 16'h8000, 16'h8000, 1, 1, 0, 0);
        chk("R4 value", seen(), 35'h0_4000_8000);
        do_op("R5 sign extension", 16'h8000, 16'h7FFF, 0, 1, 0, 0);
        chk("R5 ext bits", {32'd0, x_out}, 35'd7);
        do_op("R5 zero extension", 16'hFFFF, 16'hFFFF, 1, 0, 0, 0);
        chk("R3 unsigned value", seen(), 35'h0_FFFE_8001);

        // R7 wrap at 35 bits
        preload(1, 1, 1, 3'h7, 16'hFFFF, 16'hFFFF);
        do_op("R7 add wraps", 16'd1, 16'd1, 0, 0, 1, 0);
        chk("R7 wrap zero", seen(), '0);
        // R8 product minus accumulator
        preload(1, 1, 1, 3'h0, 16'h0000, 16'd10);
        do_op("R8 subtract", 16'd2, 16'd3, 0, 0, 1, 1);
        chk("R8 value", seen(), 35'h7_FFFF_FFFC);
        // R11 partial preloads
        preload(0, 1, 0, 3'h5, 16'hA5A5, 16'h1234);
        preload(1, 0, 1, 3'h2, 16'h5A5A, 16'hBEEF);
        preload(0, 0, 0, 3'h1, 16'h1111, 16'h2222);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0] md;
            md = 2'($urandom_range(0, 2));
            if ($urandom_range(0, 9) == 0)
                preload(1'($urandom), 1'($urandom), 1'($urandom),
                        3'($urandom), 16'($urandom), 16'($urandom));
            else
                do_op(md == 0 ? "R6 random load" : md == 1 ? "R7 random add" : "R8 random sub",
                      16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                      md != 0, md == 2);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule